// File: doc/BRIEF.md
# Partitioned Read-While-Write Flash Command Controller

This block is the command and state controller for a flash array split into equal partitions. The host writes command bytes on a bus write port. Each write carries the partition number, which is taken from the top address bits. For each partition the controller keeps a read mode. It also runs one program or erase job at a time, modelled as a busy timer, and keeps an 8-bit status word for that job.

The read path is a separate combinational lookup. For any partition number on `rd_part`, `rd_src` tells the array periphery which data source to drive: array cells, signature/ID, or the status word. A job can therefore run in one partition while reads of any kind go on in every other partition in the same cycle. An array read aimed at the partition being written is turned into a status read.

With the default `PART_BITS = 4` there are 16 partitions.

Top module: `rww_partition_ctrl`

## Requirements
- R1: After reset every partition is in array mode (`rd_src` = 0) and `status` reads 0x80: ready, both error bits clear, job partition 0.
- R2: In idle, command byte 0xFF, 0x90 or 0x70 sets the mode of the partition in `cmd_part` to array (`rd_src` 0), signature (1) or status (2). The change is visible from the cycle after the write. Other partitions keep their modes.
- R3: Byte 0x40 followed by a second write with any data byte starts a program job in the partition given with the 0x40 byte. For the PROG_CYCLES cycles after the second write, `status[7]` is 0 and `status[3:0]` holds that partition.
- R4: Byte 0x20 followed by 0xD0 starts an erase job in the partition given with the 0x20 byte, busy for ERASE_CYCLES cycles. If any other byte follows 0x20, the erase-error bit `status[5]` is set and no job starts.
- R5: While a job is busy, 0x40 sets the program-error bit `status[4]` and 0x20 sets `status[5]`. Neither enters a setup step, and the next write is decoded as a fresh command. The error bits stay set until reset.
- R6: While busy, a partition in array mode that equals the job partition reads as status (`rd_src` 2). All other partitions report their stored mode.
- R7: When a job completes, its partition's mode becomes status. This wins over a mode command to the same partition in the completion cycle.
- R8: Mode commands are accepted while busy, for any partition including the one being written.
- R9: Any other byte written in idle, including a lone 0xD0, changes nothing.
- R10: `rd_src` follows `rd_part` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Bus write strobe, one command or data byte per cycle |
| cmd_part | input | PART_BITS | Partition number from the top address bits of the write |
| cmd_data | input | 8 | Command or program data byte |
| rd_part | input | PART_BITS | Partition number from the top address bits of the read |
| rd_src | output | 2 | Read source: 0 array, 1 signature, 2 status |
| status | output | PART_BITS+4 | {ready, 0, erase error, program error, job partition} |

## Verification
On every cycle, assertions check the following:
- the job partition field holds while a job stays busy;
- both error bits are sticky;
- an array read is never granted to the busy partition;
- `rd_src` never carries the unused code;
- no busy run is longer than the longer job.

The remaining behaviour needs bench scenarios. These cover the exact busy lengths for program and erase, the setup-then-data pairing, and the rejection of a bad confirm byte. They also cover the fall-back to status mode at completion when it races a mode command, and the per-partition independence of modes under long random command mixes checked against a reference model.

// File: rtl/rww_pkg.sv
package rww_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_SIG   = 2'd1,
    SRC_STAT  = 2'd2
  } rd_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } cmd_st_e;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_SIG   = 8'h90;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

endpackage

// File: rtl/rww_cmd_decode.sv
module rww_cmd_decode
  import rww_pkg::*;
#(
  parameter int PART_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [PART_BITS-1:0] part,
  input  logic [7:0]           data,
  input  logic                 busy,
  output logic                 mode_we,
  output rd_src_e              mode_val,
  output logic                 start,
  output logic                 start_erase,
  output logic [PART_BITS-1:0] start_part,
  output logic                 set_perr,
  output logic                 set_eerr
);

  cmd_st_e              state_q, state_d;
  logic [PART_BITS-1:0] tgt_q, tgt_d;

  always_comb begin
    state_d     = state_q;
    tgt_d       = tgt_q;
    mode_we     = 1'b0;
    mode_val    = SRC_ARRAY;
    start       = 1'b0;
    start_erase = 1'b0;
    set_perr    = 1'b0;
    set_eerr    = 1'b0;
    if (we) begin
      case (state_q)
        ST_IDLE: begin
          case (data)
            CMD_RD_ARRAY: begin mode_we = 1'b1; mode_val = SRC_ARRAY; end
            CMD_RD_SIG:   begin mode_we = 1'b1; mode_val = SRC_SIG;   end
            CMD_RD_STAT:  begin mode_we = 1'b1; mode_val = SRC_STAT;  end
            CMD_PROG: begin
              if (busy) set_perr = 1'b1;
              else begin state_d = ST_PROG; tgt_d = part; end
            end
            CMD_ERASE: begin
              if (busy) set_eerr = 1'b1;
              else begin state_d = ST_ERASE; tgt_d = part; end
            end
            default: ;
          endcase
        end
        ST_PROG: begin
          start   = 1'b1;
          state_d = ST_IDLE;
        end
        ST_ERASE: begin
          if (data == CMD_CONFIRM) begin
            start       = 1'b1;
            start_erase = 1'b1;
          end else begin
            set_eerr = 1'b1;
          end
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign start_part = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

endmodule

// File: rtl/rww_job_timer.sv
module rww_job_timer #(
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase,
  output logic busy,
  output logic done
);

  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rww_mode_table.sv
module rww_mode_table
  import rww_pkg::*;
#(
  parameter  int PART_BITS = 4,
  localparam int NPART     = 1 << PART_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PART_BITS-1:0]       we_part,
  input  rd_src_e                    we_val,
  input  logic                       clr,
  input  logic [PART_BITS-1:0]       clr_part,
  output logic [NPART-1:0][1:0]      modes
);

  for (genvar i = 0; i < NPART; i++) begin : g_part
    rd_src_e mode_q, mode_d;

    always_comb begin
      mode_d = mode_q;
      if (clr && clr_part == PART_BITS'(i))     mode_d = SRC_STAT;
      else if (we && we_part == PART_BITS'(i))  mode_d = we_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= SRC_ARRAY;
      else        mode_q <= mode_d;
    end

    assign modes[i] = mode_q;
  end

endmodule

// File: rtl/rww_partition_ctrl.sv
module rww_partition_ctrl
  import rww_pkg::*;
#(
  parameter int PART_BITS    = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_we,
  input  logic [PART_BITS-1:0]   cmd_part,
  input  logic [7:0]             cmd_data,
  input  logic [PART_BITS-1:0]   rd_part,
  output logic [1:0]             rd_src,
  output logic [PART_BITS+3:0]   status
);

  localparam int NPART = 1 << PART_BITS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                 mode_we, start, start_erase, set_perr, set_eerr;
  rd_src_e              mode_val;
  logic [PART_BITS-1:0] start_part;
  logic                 busy, done;
  logic [NPART-1:0][1:0] modes;

  rww_cmd_decode #(.PART_BITS(PART_BITS)) dec_i (
    .clk(clk), .rst_n(rst_core_n), .we(cmd_we), .part(cmd_part), .data(cmd_data),
    .busy(busy), .mode_we(mode_we), .mode_val(mode_val), .start(start),
    .start_erase(start_erase), .start_part(start_part),
    .set_perr(set_perr), .set_eerr(set_eerr)
  );

  rww_job_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_core_n), .start(start), .erase(start_erase),
    .busy(busy), .done(done)
  );

  // job status word
  logic                 perr_q, perr_d, eerr_q, eerr_d;
  logic [PART_BITS-1:0] jpart_q, jpart_d;

  always_comb begin
    perr_d  = perr_q | set_perr;
    eerr_d  = eerr_q | set_eerr;
    jpart_d = start ? start_part : jpart_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      perr_q  <= 1'b0;
      eerr_q  <= 1'b0;
      jpart_q <= '0;
    end else begin
      perr_q  <= perr_d;
      eerr_q  <= eerr_d;
      jpart_q <= jpart_d;
    end
  end

  rww_mode_table #(.PART_BITS(PART_BITS)) modes_i (
    .clk(clk), .rst_n(rst_core_n), .we(mode_we), .we_part(cmd_part),
    .we_val(mode_val), .clr(done), .clr_part(jpart_q), .modes(modes)
  );

  // independent read path
  logic [1:0] sel_mode;
  always_comb begin
    sel_mode = modes[rd_part];
    if (busy && rd_part == jpart_q && sel_mode == SRC_ARRAY) rd_src = SRC_STAT;
    else                                                     rd_src = sel_mode;
  end

  assign status = {~busy, 1'b0, eerr_q, perr_q, jpart_q};

endmodule

// File: rtl/rww_partition_ctrl_chk.sv
module rww_partition_ctrl_chk #(
  parameter int PART_BITS    = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PART_BITS-1:0] rd_part,
  input logic [1:0]           rd_src,
  input logic [PART_BITS+3:0] status
);

  localparam int READY = PART_BITS + 3;
  localparam int EERR  = PART_BITS + 1;
  localparam int PERR  = PART_BITS;
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;

  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (status[READY]) run_q <= '0;
    else                    run_q <= run_q + 1'b1;
  end

  a_r3_part_held: assert property (@(posedge clk) disable iff (!rst_n)
    !status[READY] |=> (status[READY] || $stable(status[PART_BITS-1:0])));

  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !status[READY] |-> (run_q < 16'(MAXC)));

  a_r5_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[PERR] |=> status[PERR]);

  a_r5_eerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[EERR] |=> status[EERR]);

  a_r6_busy_no_array: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[READY] && rd_part == status[PART_BITS-1:0]) |-> (rd_src != 2'd0));

  a_r2_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_src != 2'd3);

endmodule

bind rww_partition_ctrl rww_partition_ctrl_chk #(
  .PART_BITS(PART_BITS), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_part(rd_part), .rd_src(rd_src), .status(status)
);

// File: tb/rww_partition_ctrl_tb_top.sv
module rww_partition_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PB         = 4;
  localparam int PROGC      = 6;
  localparam int ERASEC     = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_we;
  logic [PB-1:0] cmd_part;
  logic [7:0]    cmd_data;
  logic [PB-1:0] rd_part;
  logic [1:0]    rd_src;
  logic [PB+3:0] status;

  always #(CLK_PERIOD/2) clk = ~clk;

  rww_partition_ctrl #(.PART_BITS(PB), .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERASEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_part(cmd_part),
    .cmd_data(cmd_data), .rd_part(rd_part), .rd_src(rd_src), .status(status)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model
  logic [1:0]    m_mode [16];
  int            m_cnt;
  logic [PB-1:0] m_part;
  logic          m_perr, m_eerr;
  int            m_st;
  logic [PB-1:0] m_tgt;

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) m_mode[i] = 2'd0;
    m_cnt = 0; m_part = '0; m_perr = 1'b0; m_eerr = 1'b0; m_st = 0; m_tgt = '0;
  endfunction

  function automatic void model_step(bit we, logic [PB-1:0] p, logic [7:0] d);
    bit busy = (m_cnt != 0);
    bit done = (m_cnt == 1);
    bit start = 1'b0;
    bit erase = 1'b0;
    if (we) begin
      case (m_st)
        0: begin
          case (d)
            8'hFF: m_mode[p] = 2'd0;
            8'h90: m_mode[p] = 2'd1;
            8'h70: m_mode[p] = 2'd2;
            8'h40: if (busy) m_perr = 1'b1; else begin m_st = 1; m_tgt = p; end
            8'h20: if (busy) m_eerr = 1'b1; else begin m_st = 2; m_tgt = p; end
            default: ;
          endcase
        end
        1: begin start = 1'b1; m_st = 0; end
        default: begin
          if (d == 8'hD0) begin start = 1'b1; erase = 1'b1; end
          else m_eerr = 1'b1;
          m_st = 0;
        end
      endcase
    end
    if (done) m_mode[m_part] = 2'd2;
    if (start) begin
      m_cnt  = erase ? ERASEC : PROGC;
      m_part = m_tgt;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
  endfunction

  function automatic int exp_src(logic [PB-1:0] rp);
    if (m_cnt != 0 && rp == m_part && m_mode[rp] == 2'd0) return 2;
    return int'(m_mode[rp]);
  endfunction

  function automatic int exp_status();
    return int'({(m_cnt == 0), 1'b0, m_eerr, m_perr, m_part});
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [PB-1:0] p, logic [7:0] d, logic [PB-1:0] rp, string tag);
    @(negedge clk);
    cmd_we = we; cmd_part = p; cmd_data = d; rd_part = rp;
    #1;
    check(tag, "rd_src", int'(rd_src), exp_src(rp));
    check(tag, "status", int'(status), exp_status());
    @(posedge clk);
    #1 model_step(we, p, d);
  endtask

  task automatic idle(int n, logic [PB-1:0] rp, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 8'h00, rp, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; cmd_we = 1'b0; cmd_part = '0; cmd_data = '0; rd_part = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    check("R1", "status after reset", int'(status), 8'h80);
    for (int i = 0; i < 16; i++) cyc(1'b0, '0, 8'h00, PB'(i), "R1");

    // R2 mode commands, R10 same-cycle read lookup
    cyc(1'b1, 4'd3, 8'h90, 4'd3, "R2");
    cyc(1'b1, 4'd5, 8'h70, 4'd3, "R2");
    check("R10", "signature mode seen same cycle", int'(rd_src), 1);
    cyc(1'b0, '0, 8'h00, 4'd5, "R10");
    check("R2", "status mode on partition 5", int'(rd_src), 2);
    cyc(1'b1, 4'd5, 8'hFF, 4'd4, "R2");
    cyc(1'b0, '0, 8'h00, 4'd5, "R2");

    // R9 unknown bytes and lone confirm
    cyc(1'b1, 4'd3, 8'hD0, 4'd3, "R9");
    cyc(1'b1, 4'd3, 8'h12, 4'd3, "R9");
    cyc(1'b0, '0, 8'h00, 4'd3, "R9");
    check("R9", "status unchanged", int'(status), 8'h80);

    // R4 erase with bad confirm
    cyc(1'b1, 4'd9, 8'h20, 4'd9, "R4");
    cyc(1'b1, 4'd9, 8'hFF, 4'd9, "R4");
    cyc(1'b0, '0, 8'h00, 4'd9, "R4");
    check("R4", "erase error, still ready", int'(status), 8'hA0);

    // R3 program in partition 7, R6 reads elsewhere, R8 mode while busy
    cyc(1'b1, 4'd7, 8'h40, 4'd7, "R3");
    cyc(1'b1, 4'd0, 8'hAB, 4'd7, "R3");
    check("R3", "busy with partition 7", int'(status), 8'h27);
    check("R6", "busy partition array read", int'(rd_src), 2);
    cyc(1'b0, '0, 8'h00, 4'd3, "R6");
    cyc(1'b1, 4'd7, 8'h90, 4'd7, "R8");
    check("R8", "signature accepted on busy partition", int'(rd_src), 1);
    idle(PROGC, 4'd7, "R3");
    check("R7", "mode after program completion", int'(rd_src), 2);
    check("R3", "ready after program", int'(status[7]), 1);

    // R5 errors while busy, erase in partition 2, R7 race with mode command
    cyc(1'b1, 4'd2, 8'h20, 4'd2, "R4");
    cyc(1'b1, 4'd2, 8'hD0, 4'd2, "R4");
    check("R4", "erase busy in partition 2", int'(status), 8'h22);
    cyc(1'b1, 4'd6, 8'h40, 4'd6, "R5");
    cyc(1'b1, 4'd6, 8'hFF, 4'd6, "R5");
    check("R5", "program error set, fresh decode", int'(status), 8'h32);
    cyc(1'b1, 4'd6, 8'h20, 4'd6, "R5");
    while (m_cnt != 1) cyc(1'b0, '0, 8'h00, 4'd2, "R6");
    cyc(1'b1, 4'd2, 8'hFF, 4'd2, "R7");
    check("R7", "completion wins over same-cycle command", int'(rd_src), 2);
    check("R5", "errors sticky after job", int'(status), 8'hB2);

    // random mix checked against the model
    for (int i = 0; i < 4000; i++) begin
      int   r   = int'($urandom_range(0, 9));
      bit   we  = ($urandom_range(0, 99) < 65);
      logic [7:0] d;
      case (r)
        0, 1: d = 8'hFF;
        2:    d = 8'h90;
        3:    d = 8'h70;
        4, 5: d = 8'h40;
        6:    d = 8'h20;
        7:    d = 8'hD0;
        default: d = 8'($urandom_range(0, 255));
      endcase
      cyc(we, PB'($urandom_range(0, 15)), d, PB'($urandom_range(0, 15)),
          (m_cnt != 0) ? "R6" : "R2");
    end

    finish_run();
  end

endmodule